// File: doc/BRIEF.md
# Select-Code Prioritized Interrupt Requester

This block raises interrupt requests from a peripheral card toward its host and answers the host's interrupt poll. Each card has a four-bit select code. Codes 0 to 7 use the low-priority request line. Codes 8 to 15 use the high-priority request line. A request comes from one of two sources:

- an explicit request command from the card's local processor;
- a condition input that has been armed through an eight-bit enable mask.

A request stays pending until the host performs its designated status read. While the host polls, a card with a pending request answers if the poll's group bit matches its select-code group. It answers by pulling low one of eight host data lines, which is a one-hot decode of the three low select-code bits. The block also keeps a status flag. The flag drops when a request fires, and it can also drop when end-of-identify is seen, if that is enabled.

The enable mask is laid out from most to least significant bit as follows:

| Bit | Condition armed |
|-----|-----------------|
| 7 | service request |
| 6 | active controller |
| 5 | active talker |
| 4 | active listener |
| 3 | input register full |
| 2 | output register empty |
| 1 | other (error, device clear, end) |
| 0 | lets end-of-identify clear the status flag |

Condition input bit k pairs with mask bit k+1.

Top module: `irq_requester`

## Requirements
- R1: After reset, both request lines are low, all poll data outputs are 0, the status flag is 1 and the mask is all zero.
- R2: A request command sampled while poll is low sets the request pending. The request output appears on the next cycle, on irq_lo when sel_code[3]=0 and on irq_hi when sel_code[3]=1. Both request lines are never high together.
- R3: A request command or an armed condition sampled while poll is high is ignored. No request line rises because of it.
- R4: A pending request stays asserted until stat_rd is sampled high. If a new request fires in the same cycle as the read, the request stays asserted.
- R5: If poll is high, a request is pending and pa_msb equals sel_code[3], then one cycle later poll_drv has exactly one bit set, at index sel_code[2:0]. Otherwise poll_drv is 0.
- R6: A condition input that is high while its mask bit is set, and while poll is low, fires a request. Firing from a condition clears mask bits 7..1 and keeps bit 0, so after release a steady condition does not fire again.
- R7: A mask write whose new value enables a condition that is already high fires in the same cycle as the write. The request line is high on the next cycle.
- R8: A firing request drives the status flag to 0 on the next cycle. A mask write sets the flag to 1. A clear in the same cycle wins over the set.
- R9: A request caused only by output-register-empty (condition bit 1) clears the status flag only the first time it happens after reset. Later requests of that kind leave the flag unchanged.
- R10: When mask bit 0 is set and eoi is high, the status flag goes to 0 on the next cycle without raising a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_code | input | 4 | Card select code |
| irq_cmd | input | 1 | Local processor request command strobe |
| poll | input | 1 | Host interrupt poll in progress |
| pa_msb | input | 1 | Most significant peripheral-address bit during poll |
| stat_rd | input | 1 | Host designated status read, releases the request |
| mask_wr | input | 1 | Load strobe for the enable mask |
| mask_din | input | 8 | New enable mask value |
| cond | input | 7 | Level-sensitive condition inputs |
| eoi | input | 1 | End-of-identify seen |
| irq_lo | output | 1 | Low-priority request line |
| irq_hi | output | 1 | High-priority request line |
| poll_drv | output | 8 | Poll response, a bit set means that data line is pulled low |
| sts | output | 1 | Status flag |

## Verification
Two things can land in the same cycle: a request firing and the host's status read releasing the previous request. The bench provokes this by asserting the request command together with stat_rd. It judges the outcome by requiring the request line to still be high afterwards. The second overlap is a mask write and an already-true condition. These collide in one cycle, so the mask write's set of the status flag and the firing's clear of it land together; the bench expects the request on the next cycle with the flag low. A cycle-accurate reference model in the bench is compared against every output on every clock.

// File: rtl/irqreq_pkg.sv
package irqreq_pkg;
  localparam int unsigned COND_W = 7;
  localparam int unsigned SC_W   = 4;
  localparam int unsigned OE_BIT = 1;

  typedef enum logic {
    GRP_LO = 1'b0,
    GRP_HI = 1'b1
  } grp_e;
endpackage

// File: rtl/irqreq_arm.sv
module irqreq_arm
  import irqreq_pkg::*;
#(
  parameter int unsigned N_COND = COND_W,
  parameter int unsigned OE_IDX = OE_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr,
  input  logic [N_COND:0]   mask_din,
  input  logic [N_COND-1:0] cond,
  input  logic              eoi,
  input  logic              poll,
  input  logic              irq_cmd,
  output logic              cond_fire,
  output logic              sts,
  output logic [N_COND:0]   mask_q
);
  localparam logic [N_COND-1:0] OE_ONLY = {{(N_COND-1){1'b0}}, 1'b1} << OE_IDX;

  logic [N_COND:0]   eff_mask;
  logic [N_COND-1:0] hit;
  logic              host_fire;
  logic              only_oe;
  logic              clr_sts;
  logic              oe_seen_q;
  logic              sts_q;

  always_comb begin
    eff_mask  = mask_wr ? mask_din : mask_q;
    hit       = cond & eff_mask[N_COND:1];
    host_fire = irq_cmd & ~poll;
    cond_fire = (|hit) & ~poll;
    only_oe   = (hit == OE_ONLY) & ~host_fire;
    clr_sts   = ((host_fire | cond_fire) & ~(only_oe & oe_seen_q))
              | (eff_mask[0] & eoi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      oe_seen_q <= 1'b0;
      sts_q     <= 1'b1;
    end else begin
      mask_q    <= cond_fire ? {{N_COND{1'b0}}, eff_mask[0]} : eff_mask;
      oe_seen_q <= oe_seen_q | (cond_fire & hit[OE_IDX]);
      if (clr_sts)      sts_q <= 1'b0;
      else if (mask_wr) sts_q <= 1'b1;
    end
  end

  assign sts = sts_q;
endmodule

// File: rtl/irqreq_poll.sv
module irqreq_poll
  import irqreq_pkg::*;
#(
  parameter int unsigned SCW = SC_W,
  localparam int unsigned DL_W = 1 << (SCW - 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SCW-1:0]  sel_code,
  input  logic            poll,
  input  logic            pa_msb,
  input  logic            pend,
  output logic [DL_W-1:0] poll_drv
);
  logic [DL_W-1:0] line_sel;
  logic            answer;

  for (genvar i = 0; i < DL_W; i++) begin : g_line
    assign line_sel[i] = (sel_code[SCW-2:0] == (SCW-1)'(i));
  end

  assign answer = poll & pend & (pa_msb == sel_code[SCW-1]);

  always_ff @(posedge clk) begin
    if (rst) poll_drv <= '0;
    else     poll_drv <= answer ? line_sel : '0;
  end
endmodule

// File: rtl/irq_requester.sv
module irq_requester
  import irqreq_pkg::*;
#(
  parameter int unsigned N_COND = COND_W,
  parameter int unsigned SCW    = SC_W,
  localparam int unsigned DL_W  = 1 << (SCW - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SCW-1:0]    sel_code,
  input  logic              irq_cmd,
  input  logic              poll,
  input  logic              pa_msb,
  input  logic              stat_rd,
  input  logic              mask_wr,
  input  logic [N_COND:0]   mask_din,
  input  logic [N_COND-1:0] cond,
  input  logic              eoi,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic [DL_W-1:0]   poll_drv,
  output logic              sts
);
  logic            cond_fire;
  logic            pend_q;
  logic            pend_nxt;
  logic [N_COND:0] mask_q;
  grp_e            grp;

  irqreq_arm #(.N_COND(N_COND), .OE_IDX(OE_BIT)) u_arm (
    .clk       (clk),
    .rst       (rst),
    .mask_wr   (mask_wr),
    .mask_din  (mask_din),
    .cond      (cond),
    .eoi       (eoi),
    .poll      (poll),
    .irq_cmd   (irq_cmd),
    .cond_fire (cond_fire),
    .sts       (sts),
    .mask_q    (mask_q)
  );

  irqreq_poll #(.SCW(SCW)) u_poll (
    .clk      (clk),
    .rst      (rst),
    .sel_code (sel_code),
    .poll     (poll),
    .pa_msb   (pa_msb),
    .pend     (pend_q),
    .poll_drv (poll_drv)
  );

  assign grp = grp_e'(sel_code[SCW-1]);

  always_comb begin
    if ((irq_cmd & ~poll) | cond_fire) pend_nxt = 1'b1;
    else if (stat_rd)                  pend_nxt = 1'b0;
    else                               pend_nxt = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      irq_lo <= pend_nxt & (grp == GRP_LO);
      irq_hi <= pend_nxt & (grp == GRP_HI);
    end
  end
endmodule

// File: rtl/irq_requester_chk.sv
module irq_requester_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_cmd,
  input logic       poll,
  input logic       stat_rd,
  input logic       eoi,
  input logic [7:0] mask_q,
  input logic       irq_lo,
  input logic       irq_hi,
  input logic [7:0] poll_drv,
  input logic       sts
);
  assert_lines_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(irq_lo && irq_hi));

  assert_cmd_raises_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_cmd && !poll) |=> (irq_lo || irq_hi));

  assert_poll_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (poll && !irq_lo && !irq_hi) |=> (!irq_lo && !irq_hi));

  assert_held_R4: assert property (@(posedge clk) disable iff (rst)
    ((irq_lo || irq_hi) && !stat_rd) |=> (irq_lo || irq_hi));

  assert_drv_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(poll_drv));

  assert_drv_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !poll |=> (poll_drv == 8'h00));

  assert_fire_sts_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_cmd && !poll) |=> !sts);

  assert_eoi_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (eoi && mask_q[0]) |=> !sts);
endmodule

bind irq_requester irq_requester_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_cmd  (irq_cmd),
  .poll     (poll),
  .stat_rd  (stat_rd),
  .eoi      (eoi),
  .mask_q   (mask_q),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi),
  .poll_drv (poll_drv),
  .sts      (sts)
);

// File: tb/tb_irq_requester.sv
`timescale 1ns/1ps
module tb_irq_requester;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sel_code = '0;
  logic       irq_cmd = 1'b0, poll = 1'b0, pa_msb = 1'b0, stat_rd = 1'b0;
  logic       mask_wr = 1'b0, eoi = 1'b0;
  logic [7:0] mask_din = '0;
  logic [6:0] cond = '0;
  logic       irq_lo, irq_hi, sts;
  logic [7:0] poll_drv;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // reference model state
  bit       m_pend, m_lo, m_hi, m_sts, m_seen;
  bit [7:0] m_mask, m_drv;

  always #10 clk = ~clk;

  irq_requester dut (
    .clk(clk), .rst(rst), .sel_code(sel_code), .irq_cmd(irq_cmd), .poll(poll),
    .pa_msb(pa_msb), .stat_rd(stat_rd), .mask_wr(mask_wr), .mask_din(mask_din),
    .cond(cond), .eoi(eoi), .irq_lo(irq_lo), .irq_hi(irq_hi),
    .poll_drv(poll_drv), .sts(sts)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_pend = 0; m_lo = 0; m_hi = 0; m_sts = 1; m_seen = 0;
      m_mask = '0; m_drv = '0;
    end else begin
      bit       hf, cf, clr, only_oe;
      bit [7:0] em;
      bit [6:0] hit;
      hf  = irq_cmd && !poll;
      em  = mask_wr ? mask_din : m_mask;
      hit = cond & em[7:1];
      cf  = (hit != 0) && !poll;
      only_oe = (hit == 7'b0000010) && !hf;
      clr = ((hf || cf) && !(only_oe && m_seen)) || (em[0] && eoi);
      m_drv = (poll && m_pend && (pa_msb == sel_code[3])) ? (8'h01 << sel_code[2:0]) : 8'h00;
      if (hf || cf) m_pend = 1; else if (stat_rd) m_pend = 0;
      if (clr) m_sts = 0; else if (mask_wr) m_sts = 1;
      m_mask = cf ? {7'b0, em[0]} : em;
      m_seen = m_seen || (cf && hit[1]);
      m_lo = m_pend && !sel_code[3];
      m_hi = m_pend && sel_code[3];
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, "model irq_lo", irq_lo, m_lo);
      check(cur_req, "model irq_hi", irq_hi, m_hi);
      check(cur_req, "model poll_drv", poll_drv, m_drv);
      check(cur_req, "model sts", sts, m_sts);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic release_req();
    stat_rd = 1; tick(); stat_rd = 0;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 0;
    cur_req = "R1"; tick();
    check("R1", "irq_lo", irq_lo, 0); check("R1", "irq_hi", irq_hi, 0);
    check("R1", "sts", sts, 1);       check("R1", "poll_drv", poll_drv, 0);

    cur_req = "R2"; sel_code = 4'd3; irq_cmd = 1; tick(); irq_cmd = 0;
    check("R2", "irq_lo", irq_lo, 1); check("R2", "irq_hi", irq_hi, 0);
    check("R8", "sts after fire", sts, 0);

    cur_req = "R5"; poll = 1; pa_msb = 0; tick();
    check("R5", "poll_drv match", poll_drv, 8'h08);
    pa_msb = 1; tick(); poll = 0;
    check("R5", "poll_drv group mismatch", poll_drv, 0);

    cur_req = "R4"; tick(); check("R4", "held", irq_lo, 1);
    release_req(); check("R4", "released", irq_lo, 0);

    cur_req = "R3"; poll = 1; irq_cmd = 1; tick(); irq_cmd = 0; poll = 0;
    check("R3", "irq_lo during poll", irq_lo, 0);
    tick(); check("R3", "still idle", irq_lo, 0);

    cur_req = "R4"; sel_code = 4'd12; irq_cmd = 1; stat_rd = 1; tick();
    irq_cmd = 0; stat_rd = 0;
    check("R4", "fire wins over read", irq_hi, 1);
    release_req(); check("R4", "hi released", irq_hi, 0);

    cur_req = "R7"; cond = 7'b1000000; mask_wr = 1; mask_din = 8'h80; tick(); mask_wr = 0;
    check("R7", "immediate fire on load", irq_hi, 1);
    check("R8", "clear beats set", sts, 0);
    cur_req = "R6"; release_req(); tick(); tick();
    check("R6", "no refire after mask cleared", irq_hi, 0);
    cond = 0;
    mask_wr = 1; mask_din = 8'h10; tick(); mask_wr = 0;
    check("R8", "mask write sets sts", sts, 1);
    check("R6", "no fire before condition", irq_hi, 0);
    cond = 7'b0001000; tick(); cond = 0;
    check("R6", "level condition fires", irq_hi, 1);
    release_req();

    cur_req = "R9"; mask_wr = 1; mask_din = 8'h04; tick(); mask_wr = 0;
    cond = 7'b0000010; tick(); cond = 0;
    check("R9", "first oe fire", irq_hi, 1); check("R9", "first oe clears sts", sts, 0);
    release_req();
    mask_wr = 1; mask_din = 8'h04; tick(); mask_wr = 0;
    cond = 7'b0000010; tick(); cond = 0;
    check("R9", "second oe fire", irq_hi, 1); check("R9", "second oe keeps sts", sts, 1);
    release_req();

    cur_req = "R10"; mask_wr = 1; mask_din = 8'h01; tick(); mask_wr = 0;
    check("R10", "sts before eoi", sts, 1);
    eoi = 1; tick(); eoi = 0;
    check("R10", "eoi clears sts", sts, 0);
    check("R10", "no request from eoi", irq_hi, 0);

    cur_req = "R5";
    for (int sc = 0; sc < 16; sc++) begin
      sel_code = 4'(sc); irq_cmd = 1; tick(); irq_cmd = 0;
      check("R2", "line by group", sc >= 8 ? irq_hi : irq_lo, 1);
      poll = 1; pa_msb = sel_code[3]; tick(); poll = 0;
      check("R5", "poll line decode", poll_drv, 8'h01 << sc[2:0]);
      release_req();
    end

    tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule